// File: doc/BRIEF.md
# Token-Chained Serial Sample Output Port

This block collects filtered conversion samples from four channels into a small first-in first-out store. It sends each sample out on a single data line as a 32-bit word. The serial clock is driven from outside the block, and each word carries a status byte above the 24-bit two's-complement sample. The status byte holds a modulator error flag, the channel number, a time-break marker and a sticky overflow indicator. A drop in the active-low ready output tells the receiver that a transfer has begun. The receiver then clocks the bits out MSB first.

A static configuration input selects one of two modes:

- **Continuous mode:** a transfer begins as soon as any sample is buffered.
- **Request mode:** a polling token travels down a chain of ports. A rising token edge starts a transfer at a port that holds data. A port that holds no data forwards the token to the next port in the chain.

Filter stop and start commands control the port. A stop flushes the buffer, aborts any transfer in progress, and blocks new samples. A start issued after a stop re-arms the port and clears the overflow indicator.

Top module: `serial_sample_port`

## Requirements
- R1: Each word is laid out as follows. Bit 31 is the modulator error flag captured with the sample. Bit 26 is the time-break flag captured with the sample. Bit 24 is the overflow flag. Bits 23:0 are the sample. Bits 30, 27 and 25 are always 0.
- R2: Bits 29:28 carry the channel code: 00 for channel 1, 01 for channel 2, 10 for channel 3 and 11 for channel 4.
- R3: During a transfer, `sd_out` presents bit 31 first. Each rising edge of `sclk` advances to the next lower bit, and the line is otherwise stable.
- R4: In continuous mode (`mode_req`=0), `rdy_n` goes low within three clock cycles of a sample write into an idle, empty port. In this mode `tok_in` has no effect and `tok_out` stays 0.
- R5: In request mode (`mode_req`=1), nothing is sent until `tok_in` rises while the buffer holds data. That rising edge drives `rdy_n` low.
- R6: In request mode, while the port is idle with an empty buffer, `tok_out` equals `tok_in`. While data is buffered, `tok_out` is 0.
- R7: While further words are buffered, the next word follows directly after bit 0 and `rdy_n` stays low. After the last buffered word, `rdy_n` returns high and `sd_out` is 0.
- R8: A sample written into a full buffer (default depth 8) discards the oldest unsent entry and sets the overflow flag.
- R9: Once set, the overflow flag appears in bit 24 of every word sent afterwards.
- R10: The overflow flag is cleared only by a stop command followed later by a start command. A start on its own leaves it set. A stop empties the buffer, and writes made while stopped are discarded.
- R11: After reset, `rdy_n` is 1, `sd_out` is 0 and `tok_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | 1 = request (token) mode, 0 = continuous mode; static |
| wr_en | input | 1 | Sample write strobe |
| wr_ch | input | 2 | Channel code of the written sample |
| wr_sample | input | 24 | Two's-complement sample |
| mod_err | input | 1 | Modulator error flag, captured with the sample |
| time_brk | input | 1 | Time-break flag, captured with the sample |
| filt_stop | input | 1 | Filter stop command pulse |
| filt_start | input | 1 | Filter start command pulse |
| tok_in | input | 1 | Polling token from the previous port |
| sclk | input | 1 | External serial clock |
| rdy_n | output | 1 | Active-low transfer in progress |
| sd_out | output | 1 | Serial data, MSB first |
| tok_out | output | 1 | Polling token to the next port |

## Verification
The assertions assume the following about the inputs:

- `mode_req` changes only while the port is idle.
- Every `sclk` level lasts long enough for the synchronizer to register it.
- `tok_in` returns low between successive requests, so that each request is a fresh rising edge.

The bench meets these conditions by construction. It sets the mode only while `rdy_n` is high. It holds each `sclk` level for four system clocks. It drops the token back to 0 after every transfer it triggers. Command pulses last exactly one cycle and are never issued together.

// File: rtl/ssp_pkg.sv
// Package: shared entry type and word packing for the serial sample port.
// Assumes the fixed 32-bit word format: status byte over a 24-bit sample.
package ssp_pkg;
    localparam int SAMPLE_W = 24;
    localparam int CH_W     = 2;
    localparam int WORD_W   = 32;

    // One buffered sample together with the status captured at write time.
    typedef struct packed {
        logic                mod_err;
        logic [CH_W-1:0]     ch;
        logic                tbrk;
        logic [SAMPLE_W-1:0] sample;
    } ssp_entry_t;

    // Build the outgoing word; the overflow flag is taken at load time.
    function automatic logic [WORD_W-1:0] ssp_pack(input ssp_entry_t e, input logic ovf);
        ssp_pack = {e.mod_err, 1'b0, e.ch, 1'b0, e.tbrk, 1'b0, ovf, e.sample};
    endfunction
endpackage

// File: rtl/ssp_sync.sv
// Module: synchronizes an external level into clk and flags its rising edges.
// Assumes each input level lasts longer than STAGES+1 clk cycles.
module ssp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= async_in;
    end

    // Remaining stages, plus one extra register used for edge detection.
    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/ssp_fifo.sv
// Module: overwrite-on-full sample buffer.
// A write into a full buffer with no read in the same cycle drops the oldest
// entry and raises ovr_write for one cycle. flush empties the buffer.
module ssp_fifo
    import ssp_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr,
    input  ssp_entry_t       wdata,
    input  logic             rd,
    output ssp_entry_t       rdata,
    output logic             empty,
    output logic             full,
    output logic             ovr_write,
    output logic [CNT_W-1:0] count
);
    ssp_entry_t       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop;

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CNT_W'(DEPTH));
    assign pop       = rd && !empty;
    assign ovr_write = wr && full && !pop;
    assign rdata     = mem[rd_ptr];

    // Storage array write.
    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr) wr_ptr <= bump(wr_ptr);
            if (pop || ovr_write) rd_ptr <= bump(rd_ptr);
            if (wr && !pop && !full)  count <= count + 1'b1;
            else if (pop && !wr)      count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/ssp_shifter.sv
// Module: word shifter and transfer state.
// Loads a word when start is allowed and data exists. Shifts one bit per shift
// strobe, chains the next word after bit 0, and goes idle when the buffer is empty.
module ssp_shifter #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start_ok,
    input  logic              avail,
    input  logic [WORD_W-1:0] word_in,
    input  logic              shift_en,
    output logic              load,
    output logic              busy,
    output logic              sd_out
);
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic              last_bit;

    assign last_bit = (bitcnt == CNT_W'(WORD_W - 1));
    assign sd_out   = shreg[WORD_W-1];

    // Pop strobe: start from idle, or chain after the final bit.
    always_comb begin
        load = 1'b0;
        if (!abort) begin
            if (!busy) load = start_ok && avail;
            else       load = shift_en && last_bit && avail;
        end
    end

    // Transfer state, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy   <= 1'b0;
            shreg  <= '0;
            bitcnt <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            shreg  <= word_in;
            bitcnt <= '0;
        end else if (busy && shift_en) begin
            if (last_bit) begin
                busy   <= 1'b0;
                shreg  <= '0;
                bitcnt <= '0;
            end else begin
                shreg  <= {shreg[WORD_W-2:0], 1'b0};
                bitcnt <= bitcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_sample_port.sv
// Module: top of the token-chained serial sample output port.
// Assumes mode_req is static while a transfer is running, tok_in is synchronous
// to clk, and sclk is slow relative to clk (each level at least 3 clk cycles).
module serial_sample_port
    import ssp_pkg::*;
#(
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_req,
    input  logic                wr_en,
    input  logic [CH_W-1:0]     wr_ch,
    input  logic [SAMPLE_W-1:0] wr_sample,
    input  logic                mod_err,
    input  logic                time_brk,
    input  logic                filt_stop,
    input  logic                filt_start,
    input  logic                tok_in,
    input  logic                sclk,
    output logic                rdy_n,
    output logic                sd_out,
    output logic                tok_out
);
    logic             run_q, ovf_q, tok_q, tok_rise;
    logic             wr_acc, pop, fifo_empty, fifo_full, ovr_write, busy;
    logic             sclk_rise, start_ok;
    logic [CNT_W-1:0] fifo_count;
    ssp_entry_t       wr_entry, rd_entry;

    assign wr_acc   = wr_en && run_q && !filt_stop;
    assign wr_entry = '{mod_err: mod_err, ch: wr_ch, tbrk: time_brk, sample: wr_sample};
    assign tok_rise = tok_in && !tok_q;
    assign start_ok = mode_req ? tok_rise : 1'b1;
    assign rdy_n    = !busy;
    assign tok_out  = mode_req && !busy && fifo_empty && tok_in;

    // Token edge-detect register.
    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= 1'b0;
        else        tok_q <= tok_in;
    end

    // Filter run state and sticky overflow flag; stop wins over start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b1;
            ovf_q <= 1'b0;
        end else if (filt_stop) begin
            run_q <= 1'b0;
        end else if (filt_start && !run_q) begin
            run_q <= 1'b1;
            ovf_q <= 1'b0;
        end else if (ovr_write) begin
            ovf_q <= 1'b1;
        end
    end

    ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sclk),
        .rise     (sclk_rise)
    );

    ssp_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (filt_stop),
        .wr        (wr_acc),
        .wdata     (wr_entry),
        .rd        (pop),
        .rdata     (rd_entry),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .ovr_write (ovr_write),
        .count     (fifo_count)
    );

    ssp_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (filt_stop),
        .start_ok (start_ok),
        .avail    (!fifo_empty),
        .word_in  (ssp_pack(rd_entry, ovf_q)),
        .shift_en (sclk_rise),
        .load     (pop),
        .busy     (busy),
        .sd_out   (sd_out)
    );
endmodule

// File: rtl/ssp_checker.sv
// Checker: temporal properties of the serial sample port, bound to the top.
module ssp_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_req,
    input logic             tok_in,
    input logic             tok_out,
    input logic             rdy_n,
    input logic             sd_out,
    input logic             filt_start,
    input logic             filt_stop,
    input logic             run_q,
    input logic             ovf_q,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_count,
    input logic             wr_acc,
    input logic             pop,
    input logic             sclk_rise
);
    a_r6_token_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req && rdy_n && fifo_empty) |-> (tok_out == tok_in));

    a_r6_token_held: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> !tok_out);

    a_r4_token_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_req |-> !tok_out);

    a_r8_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && fifo_full && !pop) |=> ovf_q);

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(filt_start && !filt_stop && !run_q)) |=> ovf_q);

    a_r10_clear_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(!run_q));

    a_r10_stopped_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> fifo_empty);

    a_r3_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && !sclk_rise && !filt_stop) |=> $stable(sd_out));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_n |-> !sd_out);

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));
endmodule

bind serial_sample_port ssp_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (mode_req),
    .tok_in     (tok_in),
    .tok_out    (tok_out),
    .rdy_n      (rdy_n),
    .sd_out     (sd_out),
    .filt_start (filt_start),
    .filt_stop  (filt_stop),
    .run_q      (run_q),
    .ovf_q      (ovf_q),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count),
    .wr_acc     (wr_acc),
    .pop        (pop),
    .sclk_rise  (sclk_rise)
);

// File: tb/tb_serial_sample_port.sv
// Bench: vector table for word format in continuous mode, then directed tests.
module tb_serial_sample_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_req = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [23:0] wr_sample = '0;
    logic        mod_err = 1'b0;
    logic        time_brk = 1'b0;
    logic        filt_stop = 1'b0;
    logic        filt_start = 1'b0;
    logic        tok_in = 1'b0;
    logic        sclk = 1'b0;
    logic        rdy_n, sd_out, tok_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    serial_sample_port dut (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_sample(wr_sample), .mod_err(mod_err),
        .time_brk(time_brk), .filt_stop(filt_stop), .filt_start(filt_start),
        .tok_in(tok_in), .sclk(sclk), .rdy_n(rdy_n), .sd_out(sd_out),
        .tok_out(tok_out)
    );

    // Stimulus {ch, mod_err, time_brk, sample} and expected word (overflow 0).
    localparam int NV = 6;
    localparam logic [27:0] STIM [NV] = '{
        {2'b00, 1'b0, 1'b0, 24'h000001},
        {2'b01, 1'b1, 1'b0, 24'h7FFFFF},
        {2'b10, 1'b0, 1'b1, 24'h800000},
        {2'b11, 1'b1, 1'b1, 24'hA5C3F0},
        {2'b11, 1'b0, 1'b0, 24'hFFFFFF},
        {2'b00, 1'b0, 1'b1, 24'h123456}
    };
    localparam logic [31:0] EXPW [NV] = '{
        32'h00000001, 32'h907FFFFF, 32'h24800000,
        32'hB4A5C3F0, 32'h30FFFFFF, 32'h04123456
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_s(input logic [1:0] ch, input logic me, input logic tb,
                           input logic [23:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch; mod_err = me; time_brk = tb; wr_sample = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); filt_stop = 1'b1;
        @(negedge clk); filt_stop = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); filt_start = 1'b1;
        @(negedge clk); filt_start = 1'b0;
    endtask

    // Sample each bit before the sclk rise that advances past it.
    task automatic read_word(output logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            @(negedge clk);
            w[i] = sd_out;
            sclk = 1'b1;
            cyc(4);
            sclk = 1'b0;
            cyc(4);
        end
    endtask

    initial begin
        logic [31:0] w;
        cyc(3);
        // R11: reset state
        chk("R11 rdy_n", {31'd0, rdy_n}, 32'd1);
        chk("R11 sd_out", {31'd0, sd_out}, 32'd0);
        chk("R11 tok_out", {31'd0, tok_out}, 32'd0);
        rst_n = 1'b1;
        cyc(2);

        // R4: continuous mode ignores the token
        tok_in = 1'b1; cyc(3);
        chk("R4 tok_out blocked", {31'd0, tok_out}, 32'd0);
        chk("R4 no start on token", {31'd0, rdy_n}, 32'd1);
        tok_in = 1'b0; cyc(2);

        // R1/R2/R3/R4/R7: table of single-word transfers
        for (int v = 0; v < NV; v++) begin
            write_s(STIM[v][27:26], STIM[v][25], STIM[v][24], STIM[v][23:0]);
            cyc(3);
            chk("R4 auto start", {31'd0, rdy_n}, 32'd0);
            read_word(w);
            chk("R1 R2 R3 word", w, EXPW[v]);
            cyc(2);
            chk("R7 ready high after last", {31'd0, rdy_n}, 32'd1);
        end

        // R7: back-to-back words keep ready low
        write_s(2'b01, 1'b0, 1'b0, 24'h0000AA);
        write_s(2'b10, 1'b0, 1'b0, 24'h0000BB);
        cyc(2);
        read_word(w);
        chk("R7 first chained", w, 32'h100000AA);
        chk("R7 ready held", {31'd0, rdy_n}, 32'd0);
        read_word(w);
        chk("R7 second chained", w, 32'h200000BB);
        cyc(2);
        chk("R7 ready released", {31'd0, rdy_n}, 32'd1);

        // R6: request mode passes the token while empty
        mode_req = 1'b1; cyc(2);
        tok_in = 1'b1; cyc(1);
        chk("R6 token passed", {31'd0, tok_out}, 32'd1);
        tok_in = 1'b0; cyc(1);
        chk("R6 token low passed", {31'd0, tok_out}, 32'd0);

        // R8: nine writes into depth eight, no token yet
        for (int i = 0; i < 9; i++)
            write_s(2'(i % 4), 1'b0, 1'b0, 24'h000100 + 24'(i));
        cyc(3);
        chk("R5 waits for token", {31'd0, rdy_n}, 32'd1);
        pulse_start();  // R10: start alone while running
        tok_in = 1'b1; cyc(1);
        chk("R6 token held with data", {31'd0, tok_out}, 32'd0);
        cyc(2);
        chk("R5 token starts", {31'd0, rdy_n}, 32'd0);
        for (int i = 1; i < 9; i++) begin
            read_word(w);
            chk("R8 R9 overflow word", w,
                (32'(i % 4) << 28) | 32'h01000000 | (32'h100 + 32'(i)));
            if (i < 8) chk("R7 ready held", {31'd0, rdy_n}, 32'd0);
        end
        cyc(2);
        chk("R7 ready after burst", {31'd0, rdy_n}, 32'd1);
        tok_in = 1'b0; cyc(2);

        // R9: flag persists on later words
        write_s(2'b11, 1'b0, 1'b0, 24'h00DEAD);
        tok_in = 1'b1; cyc(3);
        read_word(w);
        chk("R9 sticky", w, 32'h3100DEAD);
        tok_in = 1'b0; cyc(3);

        // R10: stop flushes and blocks writes; stop then start clears flag
        write_s(2'b00, 1'b0, 1'b0, 24'h000777);
        pulse_stop();
        write_s(2'b01, 1'b0, 1'b0, 24'h000888);
        tok_in = 1'b1; cyc(1);
        chk("R10 flushed token passes", {31'd0, tok_out}, 32'd1);
        chk("R10 no transfer when stopped", {31'd0, rdy_n}, 32'd1);
        tok_in = 1'b0; cyc(1);
        pulse_start();
        write_s(2'b10, 1'b0, 1'b0, 24'h0ABCDE);
        tok_in = 1'b1; cyc(3);
        read_word(w);
        chk("R10 flag cleared", w, 32'h200ABCDE);
        tok_in = 1'b0; cyc(3);
        chk("R7 idle line", {31'd0, sd_out}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule